// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a bank of interrupt sources and pushes deliveries toward a presentation controller. Each source has a target server, a priority, and four flags: asserted, masked-pending, resend and a mask. The mask is the priority value 0xFF. A requester issues one operation at a time on a single request port: trigger, lower, end-of-interrupt, resend scan or configure. The block then runs the whole delivery sequence that follows on its own.

The presenter answers each delivery attempt in one of three ways. It can accept the interrupt. It can accept it and hand back a source it displaced. Or it can refuse it, and then it also reports its need-resend flag. No interrupt is ever lost:

- A refused source is marked for resend, and this bank's bit is raised in the presenter's resend map.
- A displaced source is redelivered at once to its configured target.
- A masked source records that it is pending, on first delivery and on resend alike.

Source numbers are 10 bits wide. The bank covers the sources from `BASE` up to `BASE+N_SRC-1`. Only one operation runs at a time: the block stays busy until the operation and every delivery it causes have finished.

Top module: `irq_source_bank`

## Requirements
- R1: After reset `op_ready_o` is 1, `dlv_valid_o`, `rmap_set_o` and `err_o` are 0, every source priority is 0xFF (masked), and all flags are clear.
- R2: Operation codes on `op_kind_i` are: 0 trigger message, 1 trigger level, 2 lower, 3 end-of-interrupt, 4 resend scan, 5 configure. Codes 6 and 7 do nothing. A trigger of an unmasked source raises `dlv_valid_o` with the source number, server and priority. These outputs hold steady until `dlv_ack_i`.
- R3: A delivery of a source whose priority is 0xFF makes no attempt and sets its masked-pending flag. A later configure that moves the priority from 0xFF to another value clears the flag and delivers exactly once. A configure with the flag clear delivers nothing.
- R4: A refusal (`dlv_ack_i`=1, `dlv_accept_i`=0) sets the source's resend flag. One cycle later it pulses `rmap_set_o` with `rmap_server_o` set to the target server.
- R5: If `nr_flag_i` is 0 at a refusal, the same source is retried at once. The retry clears the resend flag, as every attempt does.
- R6: If an accepted delivery reports a displaced source in `dlv_displaced_i`, and that source is neither 0 (none) nor `IPI_SRC`, the displaced source is delivered next using its own configured server and priority.
- R7: A resend scan visits sources in ascending index order. It delivers only those whose resend flag is set, once each. The attempt clears the flag, so a second scan right after delivers nothing.
- R8: A source with its resend flag set that has been masked meanwhile sets masked-pending during the scan and makes no attempt. Unmasking it later delivers it.
- R9: An end-of-interrupt redelivers a source only while its asserted flag is set. A level trigger sets that flag and lower clears it; a message trigger never sets it. An end-of-interrupt for `IPI_SRC` does nothing and raises no error.
- R10: A trigger, lower, end-of-interrupt or configure naming a source outside the bank pulses `err_o` for one cycle, one cycle after acceptance, and changes no source state. A displaced source outside the bank does the same.
- R11: `op_ready_o` stays 0 from the cycle after an operation that starts a delivery is accepted until that operation's last delivery has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request |
| op_ready_o | output | 1 | Block idle; request taken when both are high |
| op_kind_i | input | 3 | Operation code |
| op_src_i | input | 10 | Source number of the operation |
| op_server_i | input | SRV_W | Target server for configure |
| op_prio_i | input | 8 | Priority for configure, 0xFF masks |
| dlv_valid_o | output | 1 | Delivery attempt presented |
| dlv_src_o | output | 10 | Source number being delivered |
| dlv_server_o | output | SRV_W | Target server of the attempt |
| dlv_prio_o | output | 8 | Priority of the attempt |
| dlv_ack_i | input | 1 | Presenter answers this cycle |
| dlv_accept_i | input | 1 | 1 accepted, 0 refused |
| dlv_displaced_i | input | 10 | Source displaced by an accepted delivery, 0 for none |
| nr_flag_i | input | 1 | Presenter's need-resend flag at refusal |
| rmap_set_o | output | 1 | Set this bank's bit in a server's resend map |
| rmap_server_o | output | SRV_W | Server whose resend map is set |
| err_o | output | 1 | Illegal source number pulse |

## Verification
The hardest situations to reach are the chained ones. One is a refusal that arrives while the presenter's need-resend flag has already dropped, which forces an immediate retry. The other is an accepted delivery that displaces another source of the same bank, so a second delivery must start with no new request. The bench contains a scripted presenter model. Before each trigger the bench queues that model's answers: accept or refuse, a displaced source, the flag value and an acknowledge delay. Each chain then follows from a single trigger. Masked resends are reached by first refusing a source, then masking it, then scanning.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int SRC_W = 10;
  localparam logic [7:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [2:0] {
    OP_TRIG_MSG = 3'd0,
    OP_TRIG_LVL = 3'd1,
    OP_LOWER    = 3'd2,
    OP_EOI      = 3'd3,
    OP_SCAN     = 3'd4,
    OP_CFG      = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DLV  = 2'd2,
    ST_WAIT = 2'd3
  } seq_st_e;
endpackage

// File: rtl/irq_src_decode.sv
module irq_src_decode
  import irq_src_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int BASE  = 16,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [SRC_W-1:0] src_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [SRC_W-1:0] BASE_V = SRC_W'(BASE);
  localparam logic [SRC_W-1:0] CNT_V  = SRC_W'(N_SRC);

  logic [SRC_W-1:0] off;

  assign off   = src_i - BASE_V;
  assign hit_o = (src_i >= BASE_V) && (off < CNT_V);
  assign idx_o = off[IDX_W-1:0];
endmodule

// File: rtl/irq_src_table.sv
module irq_src_table
  import irq_src_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int SRV_W = 4,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // request-side writes
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic             cfg_we_i,
  input  logic [SRV_W-1:0] cfg_server_i,
  input  logic [7:0]       cfg_prio_i,
  input  logic             asrt_set_i,
  input  logic             asrt_clr_i,
  input  logic             mp_clr_i,
  // sequence-side writes
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic             rs_clr_i,
  input  logic             rs_set_i,
  input  logic             mp_set_i,
  // read port
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [SRV_W-1:0] rd_server_o,
  output logic [7:0]       rd_prio_o,
  output logic             rd_asrt_o,
  output logic             rd_mp_o,
  output logic [N_SRC-1:0] rs_vec_o
);
  logic [SRV_W-1:0] server_q [N_SRC];
  logic [7:0]       prio_q   [N_SRC];
  logic [N_SRC-1:0] asrt_q, mp_q, rs_q;
  logic [N_SRC-1:0] sel_op, sel_cur;

  for (genvar g = 0; g < N_SRC; g++) begin : g_sel
    assign sel_op[g]  = (op_idx_i == IDX_W'(g));
    assign sel_cur[g] = (cur_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SRC; i++) begin
        server_q[i] <= '0;
        prio_q[i]   <= PRIO_MASKED;
      end
      asrt_q <= '0;
      mp_q   <= '0;
      rs_q   <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (cfg_we_i && sel_op[i]) begin
          server_q[i] <= cfg_server_i;
          prio_q[i]   <= cfg_prio_i;
        end
        if (asrt_set_i && sel_op[i])      asrt_q[i] <= 1'b1;
        else if (asrt_clr_i && sel_op[i]) asrt_q[i] <= 1'b0;
        if (mp_set_i && sel_cur[i])       mp_q[i] <= 1'b1;
        else if (mp_clr_i && sel_op[i])   mp_q[i] <= 1'b0;
        if (rs_set_i && sel_cur[i])       rs_q[i] <= 1'b1;
        else if (rs_clr_i && sel_cur[i])  rs_q[i] <= 1'b0;
      end
    end
  end

  assign rd_server_o = server_q[rd_idx_i];
  assign rd_prio_o   = prio_q[rd_idx_i];
  assign rd_asrt_o   = asrt_q[rd_idx_i];
  assign rd_mp_o     = mp_q[rd_idx_i];
  assign rs_vec_o    = rs_q;

  // R3
  mp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mp_set_i |=> mp_q[$past(cur_idx_i)]);

  // R7
  rs_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_clr_i |=> !rs_q[$past(cur_idx_i)]);
endmodule

// File: rtl/irq_src_seq.sv
module irq_src_seq
  import irq_src_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int SRV_W   = 4,
  parameter int IPI_SRC = 2,
  parameter int IDX_W   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  op_kind_e         op_kind_i,
  input  logic [SRC_W-1:0] op_src_i,
  input  logic             op_hit_i,
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic [7:0]       op_prio_i,
  // table
  input  logic [SRV_W-1:0] rd_server_i,
  input  logic [7:0]       rd_prio_i,
  input  logic             rd_mp_i,
  input  logic             rd_asrt_i,
  input  logic [N_SRC-1:0] rs_vec_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             cfg_we_o,
  output logic             asrt_set_o,
  output logic             asrt_clr_o,
  output logic             mp_clr_o,
  output logic             mp_set_o,
  output logic             rs_clr_o,
  output logic             rs_set_o,
  // presenter
  output logic             dlv_valid_o,
  input  logic             dlv_ack_i,
  input  logic             dlv_accept_i,
  input  logic [SRC_W-1:0] dlv_displaced_i,
  input  logic             disp_hit_i,
  input  logic [IDX_W-1:0] disp_idx_i,
  input  logic             nr_flag_i,
  output logic             rmap_set_o,
  output logic [SRV_W-1:0] rmap_server_o,
  output logic             err_o
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_SRC - 1);
  localparam logic [SRC_W-1:0] IPI_V = SRC_W'(IPI_SRC);

  seq_st_e          state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d, scan_q, scan_d;
  logic             in_scan_q, in_scan_d;
  logic             err_q, err_d, rmap_q, rmap_d;
  logic [SRV_W-1:0] rmap_srv_q;
  logic             fin;

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    scan_d     = scan_q;
    in_scan_d  = in_scan_q;
    err_d      = 1'b0;
    rmap_d     = 1'b0;
    fin        = 1'b0;
    cfg_we_o   = 1'b0;
    asrt_set_o = 1'b0;
    asrt_clr_o = 1'b0;
    mp_clr_o   = 1'b0;
    mp_set_o   = 1'b0;
    rs_clr_o   = 1'b0;
    rs_set_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (op_valid_i) begin
          unique case (op_kind_i)
            OP_TRIG_MSG, OP_TRIG_LVL: begin
              if (!op_hit_i) err_d = 1'b1;
              else begin
                asrt_set_o = (op_kind_i == OP_TRIG_LVL);
                cur_d      = op_idx_i;
                state_d    = ST_DLV;
              end
            end
            OP_LOWER: begin
              if (!op_hit_i) err_d = 1'b1;
              else asrt_clr_o = 1'b1;
            end
            OP_EOI: begin
              if (op_src_i == IPI_V) begin
                // no end-of-interrupt action for the IPI source
              end else if (!op_hit_i) err_d = 1'b1;
              else if (rd_asrt_i) begin
                cur_d   = op_idx_i;
                state_d = ST_DLV;
              end
            end
            OP_SCAN: begin
              scan_d    = '0;
              in_scan_d = 1'b1;
              state_d   = ST_SCAN;
            end
            OP_CFG: begin
              if (!op_hit_i) err_d = 1'b1;
              else begin
                cfg_we_o = 1'b1;
                if (rd_prio_i == PRIO_MASKED && op_prio_i != PRIO_MASKED && rd_mp_i) begin
                  mp_clr_o = 1'b1;
                  cur_d    = op_idx_i;
                  state_d  = ST_DLV;
                end
              end
            end
            default: ;
          endcase
        end
      end
      ST_SCAN: begin
        if (rs_vec_i[scan_q]) begin
          cur_d   = scan_q;
          state_d = ST_DLV;
        end else fin = 1'b1;
      end
      ST_DLV: begin
        rs_clr_o = 1'b1;
        if (rd_prio_i == PRIO_MASKED) begin
          mp_set_o = 1'b1;
          fin      = 1'b1;
        end else state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (dlv_ack_i) begin
          if (dlv_accept_i) begin
            if (dlv_displaced_i != '0 && dlv_displaced_i != IPI_V) begin
              if (disp_hit_i) begin
                cur_d   = disp_idx_i;
                state_d = ST_DLV;
              end else begin
                err_d = 1'b1;
                fin   = 1'b1;
              end
            end else fin = 1'b1;
          end else begin
            rs_set_o = 1'b1;
            rmap_d   = 1'b1;
            if (!nr_flag_i) state_d = ST_DLV;
            else fin = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (fin) begin
      if (in_scan_q) begin
        if (scan_q == LAST) begin
          in_scan_d = 1'b0;
          state_d   = ST_IDLE;
        end else begin
          scan_d  = scan_q + 1'b1;
          state_d = ST_SCAN;
        end
      end else state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      scan_q     <= '0;
      in_scan_q  <= 1'b0;
      err_q      <= 1'b0;
      rmap_q     <= 1'b0;
      rmap_srv_q <= '0;
    end else begin
      state_q   <= state_d;
      cur_q     <= cur_d;
      scan_q    <= scan_d;
      in_scan_q <= in_scan_d;
      err_q     <= err_d;
      rmap_q    <= rmap_d;
      if (rmap_d) rmap_srv_q <= rd_server_i;
    end
  end

  assign op_ready_o    = (state_q == ST_IDLE);
  assign dlv_valid_o   = (state_q == ST_WAIT);
  assign rd_idx_o      = (state_q == ST_IDLE) ? op_idx_i : cur_q;
  assign cur_idx_o     = cur_q;
  assign err_o         = err_q;
  assign rmap_set_o    = rmap_q;
  assign rmap_server_o = rmap_srv_q;

  // R2
  dlv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && !dlv_ack_i |=> dlv_valid_o && $stable(cur_q));

  // R5
  retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && dlv_ack_i && !dlv_accept_i && !nr_flag_i |=> state_q == ST_DLV && $stable(cur_q));

  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o && op_kind_i == OP_TRIG_MSG && op_hit_i |=> !op_ready_o);

  // R4
  rmap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmap_set_o |-> $past(dlv_valid_o) && !$past(dlv_accept_i));
endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
  import irq_src_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int SRV_W   = 4,
  parameter int BASE    = 16,
  parameter int IPI_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  logic [2:0]       op_kind_i,
  input  logic [9:0]       op_src_i,
  input  logic [SRV_W-1:0] op_server_i,
  input  logic [7:0]       op_prio_i,
  output logic             dlv_valid_o,
  output logic [9:0]       dlv_src_o,
  output logic [SRV_W-1:0] dlv_server_o,
  output logic [7:0]       dlv_prio_o,
  input  logic             dlv_ack_i,
  input  logic             dlv_accept_i,
  input  logic [9:0]       dlv_displaced_i,
  input  logic             nr_flag_i,
  output logic             rmap_set_o,
  output logic [SRV_W-1:0] rmap_server_o,
  output logic             err_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic             op_hit, disp_hit;
  logic [IDX_W-1:0] op_idx, disp_idx, rd_idx, cur_idx;
  logic [SRV_W-1:0] rd_server;
  logic [7:0]       rd_prio;
  logic             rd_asrt, rd_mp;
  logic [N_SRC-1:0] rs_vec;
  logic             cfg_we, asrt_set, asrt_clr, mp_clr, mp_set, rs_clr, rs_set;

  irq_src_decode #(.N_SRC(N_SRC), .BASE(BASE), .IDX_W(IDX_W)) u_op_dec (
    .src_i(op_src_i), .hit_o(op_hit), .idx_o(op_idx)
  );

  irq_src_decode #(.N_SRC(N_SRC), .BASE(BASE), .IDX_W(IDX_W)) u_disp_dec (
    .src_i(dlv_displaced_i), .hit_o(disp_hit), .idx_o(disp_idx)
  );

  irq_src_table #(.N_SRC(N_SRC), .SRV_W(SRV_W), .IDX_W(IDX_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_idx_i     (op_idx),
    .cfg_we_i     (cfg_we),
    .cfg_server_i (op_server_i),
    .cfg_prio_i   (op_prio_i),
    .asrt_set_i   (asrt_set),
    .asrt_clr_i   (asrt_clr),
    .mp_clr_i     (mp_clr),
    .cur_idx_i    (cur_idx),
    .rs_clr_i     (rs_clr),
    .rs_set_i     (rs_set),
    .mp_set_i     (mp_set),
    .rd_idx_i     (rd_idx),
    .rd_server_o  (rd_server),
    .rd_prio_o    (rd_prio),
    .rd_asrt_o    (rd_asrt),
    .rd_mp_o      (rd_mp),
    .rs_vec_o     (rs_vec)
  );

  irq_src_seq #(.N_SRC(N_SRC), .SRV_W(SRV_W), .IPI_SRC(IPI_SRC), .IDX_W(IDX_W)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .op_valid_i      (op_valid_i),
    .op_ready_o      (op_ready_o),
    .op_kind_i       (op_kind_e'(op_kind_i)),
    .op_src_i        (op_src_i),
    .op_hit_i        (op_hit),
    .op_idx_i        (op_idx),
    .op_prio_i       (op_prio_i),
    .rd_server_i     (rd_server),
    .rd_prio_i       (rd_prio),
    .rd_mp_i         (rd_mp),
    .rd_asrt_i       (rd_asrt),
    .rs_vec_i        (rs_vec),
    .rd_idx_o        (rd_idx),
    .cur_idx_o       (cur_idx),
    .cfg_we_o        (cfg_we),
    .asrt_set_o      (asrt_set),
    .asrt_clr_o      (asrt_clr),
    .mp_clr_o        (mp_clr),
    .mp_set_o        (mp_set),
    .rs_clr_o        (rs_clr),
    .rs_set_o        (rs_set),
    .dlv_valid_o     (dlv_valid_o),
    .dlv_ack_i       (dlv_ack_i),
    .dlv_accept_i    (dlv_accept_i),
    .dlv_displaced_i (dlv_displaced_i),
    .disp_hit_i      (disp_hit),
    .disp_idx_i      (disp_idx),
    .nr_flag_i       (nr_flag_i),
    .rmap_set_o      (rmap_set_o),
    .rmap_server_o   (rmap_server_o),
    .err_o           (err_o)
  );

  assign dlv_src_o    = SRC_W'(BASE) + {{(SRC_W-IDX_W){1'b0}}, cur_idx};
  assign dlv_server_o = rd_server;
  assign dlv_prio_o   = rd_prio;

  // R3
  masked_no_dlv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> dlv_prio_o != PRIO_MASKED);

  // R10
  err_no_dlv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !dlv_valid_o);
endmodule

// File: tb/irq_source_bank_tb_top.sv
module irq_source_bank_tb_top;
  localparam int SRV_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic op_valid_i = 1'b0;
  logic op_ready_o;
  logic [2:0] op_kind_i = '0;
  logic [9:0] op_src_i = '0;
  logic [SRV_W-1:0] op_server_i = '0;
  logic [7:0] op_prio_i = '0;
  logic dlv_valid_o;
  logic [9:0] dlv_src_o;
  logic [SRV_W-1:0] dlv_server_o;
  logic [7:0] dlv_prio_o;
  logic dlv_ack_i = 1'b0;
  logic dlv_accept_i = 1'b0;
  logic [9:0] dlv_displaced_i = '0;
  logic nr_flag_i = 1'b1;
  logic rmap_set_o;
  logic [SRV_W-1:0] rmap_server_o;
  logic err_o;

  always #10 clk_i = ~clk_i;

  irq_source_bank dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int dlv_cnt = 0, rmap_cnt = 0, err_cnt = 0;
  logic [SRV_W-1:0] rmap_last;
  logic [21:0] exp_q[$];   // {src, server, prio}
  string       tag_q[$];
  logic [15:0] rsp_q[$];   // {delay[3:0], nr, accept, displaced[9:0]}

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pulse counters
  initial forever begin
    @(negedge clk_i);
    if (rmap_set_o) begin rmap_cnt++; rmap_last = rmap_server_o; end
    if (err_o) err_cnt++;
  end

  // presenter model and scoreboard monitor
  initial forever begin
    @(negedge clk_i);
    dlv_ack_i = 1'b0;
    if (dlv_valid_o) begin
      logic [15:0] r;
      logic [21:0] got;
      dlv_cnt++;
      got = {dlv_src_o, dlv_server_o, dlv_prio_o};
      if (exp_q.size() == 0) chk(0, "R2", "unexpected delivery", 32'(got), 0);
      else begin
        string t;
        logic [21:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, "delivery {src,srv,prio}", 32'(got), 32'(e));
      end
      r = (rsp_q.size() != 0) ? rsp_q.pop_front() : {4'd0, 1'b1, 1'b1, 10'd0};
      for (int d = 0; d < int'(r[15:12]); d++) begin
        @(negedge clk_i);
        chk(dlv_valid_o && {dlv_src_o, dlv_server_o, dlv_prio_o} == got, "R2",
            "held until ack", 32'({dlv_src_o, dlv_server_o, dlv_prio_o}), 32'(got));
      end
      nr_flag_i       = r[11];
      dlv_accept_i    = r[10];
      dlv_displaced_i = r[9:0];
      dlv_ack_i       = 1'b1;
    end
  end

  task automatic expect_dlv(input int src, input int srv, input int prio, input string t);
    exp_q.push_back({10'(src), 4'(srv), 8'(prio)});
    tag_q.push_back(t);
  endtask

  task automatic rsp(input int delay, input bit nr, input bit acc, input int disp);
    rsp_q.push_back({4'(delay), nr, acc, 10'(disp)});
  endtask

  task automatic op(input int kind, input int src, input int srv, input int prio);
    @(negedge clk_i);
    while (!op_ready_o) @(negedge clk_i);
    op_valid_i  = 1'b1;
    op_kind_i   = 3'(kind);
    op_src_i    = 10'(src);
    op_server_i = 4'(srv);
    op_prio_i   = 8'(prio);
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  task automatic settle(input string t);
    repeat (2) @(negedge clk_i);
    while (!op_ready_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, t, "expected deliveries outstanding", exp_q.size(), 0);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(op_ready_o == 1'b1, "R1", "op_ready_o", op_ready_o, 1);
    chk(dlv_valid_o == 1'b0, "R1", "dlv_valid_o", dlv_valid_o, 0);
    chk(rmap_set_o == 1'b0 && err_o == 1'b0, "R1", "rmap/err", {rmap_set_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 / R3: unconfigured source is masked, marks pending; unmask delivers once
    c0 = dlv_cnt;
    op(0, 18, 0, 0);
    settle("R3");
    chk(dlv_cnt == c0, "R1", "masked at reset, no attempt", dlv_cnt - c0, 0);
    expect_dlv(18, 3, 4, "R3");
    op(5, 18, 3, 4);
    settle("R3");
    c0 = dlv_cnt;
    op(5, 18, 3, 6);
    settle("R3");
    chk(dlv_cnt == c0, "R3", "configure without pending flag", dlv_cnt - c0, 0);

    // R2 basic delivery with held acknowledge, R11 busy
    op(5, 20, 1, 2);
    rsp(3, 1, 1, 0);
    expect_dlv(20, 1, 2, "R2");
    op(0, 20, 0, 0);
    chk(op_ready_o == 1'b0, "R11", "busy after trigger", op_ready_o, 0);
    settle("R2");

    // R4 refusal with need-resend set, then R7 scan redelivers once
    op(5, 22, 5, 3);
    c0 = rmap_cnt;
    rsp(0, 1, 0, 0);
    expect_dlv(22, 5, 3, "R4");
    op(0, 22, 0, 0);
    settle("R4");
    chk(rmap_cnt == c0 + 1, "R4", "resend map pulses", rmap_cnt - c0, 1);
    chk(rmap_last == 4'd5, "R4", "resend map server", rmap_last, 5);
    expect_dlv(22, 5, 3, "R7");
    op(4, 0, 0, 0);
    settle("R7");
    c0 = dlv_cnt;
    op(4, 0, 0, 0);
    settle("R7");
    chk(dlv_cnt == c0, "R7", "second scan idle", dlv_cnt - c0, 0);

    // R5 refusal with need-resend clear retries at once
    c0 = rmap_cnt;
    rsp(0, 0, 0, 0);
    rsp(0, 1, 1, 0);
    expect_dlv(20, 1, 2, "R5");
    expect_dlv(20, 1, 2, "R5");
    op(0, 20, 0, 0);
    settle("R5");
    chk(rmap_cnt == c0 + 1, "R5", "resend map pulse on retry", rmap_cnt - c0, 1);
    c0 = dlv_cnt;
    op(4, 0, 0, 0);
    settle("R5");
    chk(dlv_cnt == c0, "R5", "retry cleared resend flag", dlv_cnt - c0, 0);

    // R6 displaced source redelivered; IPI displacement ignored
    op(5, 24, 7, 1);
    rsp(0, 1, 1, 20);
    expect_dlv(24, 7, 1, "R6");
    expect_dlv(20, 1, 2, "R6");
    op(0, 24, 0, 0);
    settle("R6");
    c0 = dlv_cnt;
    rsp(0, 1, 1, 2);
    expect_dlv(24, 7, 1, "R6");
    op(0, 24, 0, 0);
    settle("R6");
    chk(dlv_cnt == c0 + 1, "R6", "IPI displacement not redelivered", dlv_cnt - c0, 1);

    // R7 ascending scan order
    op(5, 26, 2, 9);
    op(5, 17, 6, 8);
    rsp(0, 1, 0, 0);
    expect_dlv(26, 2, 9, "R7");
    op(0, 26, 0, 0);
    settle("R7");
    rsp(0, 1, 0, 0);
    expect_dlv(17, 6, 8, "R7");
    op(0, 17, 0, 0);
    settle("R7");
    expect_dlv(17, 6, 8, "R7");
    expect_dlv(26, 2, 9, "R7");
    op(4, 0, 0, 0);
    settle("R7");

    // R8 masked source on resend keeps pending
    op(5, 28, 2, 5);
    rsp(0, 1, 0, 0);
    expect_dlv(28, 2, 5, "R8");
    op(0, 28, 0, 0);
    settle("R8");
    op(5, 28, 2, 255);
    c0 = dlv_cnt;
    op(4, 0, 0, 0);
    settle("R8");
    chk(dlv_cnt == c0, "R8", "masked scan makes no attempt", dlv_cnt - c0, 0);
    expect_dlv(28, 2, 5, "R8");
    op(5, 28, 2, 5);
    settle("R8");

    // R9 end-of-interrupt behaviour
    op(5, 30, 4, 7);
    expect_dlv(30, 4, 7, "R9");
    op(1, 30, 0, 0);
    settle("R9");
    expect_dlv(30, 4, 7, "R9");
    op(3, 30, 0, 0);
    settle("R9");
    op(2, 30, 0, 0);
    c0 = dlv_cnt;
    op(3, 30, 0, 0);
    op(3, 20, 0, 0);
    settle("R9");
    chk(dlv_cnt == c0, "R9", "eoi of unasserted sources", dlv_cnt - c0, 0);
    c0 = err_cnt;
    op(3, 2, 0, 0);
    settle("R9");
    chk(err_cnt == c0, "R9", "eoi of IPI raises no error", err_cnt - c0, 0);

    // R10 illegal source numbers
    c0 = err_cnt;
    op(0, 5, 0, 0);
    chk(err_o == 1'b1, "R10", "err pulse timing", err_o, 1);
    settle("R10");
    op(5, 40, 9, 0);
    settle("R10");
    chk(err_cnt == c0 + 2, "R10", "error pulses", err_cnt - c0, 2);
    expect_dlv(24, 7, 1, "R10");
    op(0, 24, 0, 0);
    settle("R10");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule